// File: doc/BRIEF.md
# External Memory Access Timing Sequencer

This block shapes the control strobes of one access to an external parallel memory device. A start pulse launches the access. From the next clock on, a tick counter runs in units of the functional clock. Each strobe (chip select, address valid, output enable, write enable) turns active on its own programmable tick and turns inactive on another. Chip select and address valid each have separate release ticks for reads and for writes. The access lasts until the counter reaches the cycle length for its direction, and a one-cycle done pulse marks the final tick.

For reads, a capture strobe marks the data access tick, and the read data bus is registered at the end of that tick. In synchronous mode the block also drives a memory clock derived from a 2-bit divider code. The direction, mode and divider are sampled when the access is launched. The timing fields are plain input ports and must stay steady while an access runs.

Top module: `emt_access_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, cs_n, adv_n, oe_n and we_n are 1, and cap_stb, mem_clk, done and rd_q are 0.
- R2: A start seen while idle launches an access. Tick 0 is the clock cycle after the one in which start was sampled. The access covers ticks 0 to L, where L is rd_cycle for a read (is_write=0) and wr_cycle for a write (is_write=1), so it lasts L+1 cycles.
- R3: done is 1 for exactly one cycle, during tick L.
- R4: cs_n is 0 during the ticks t with cs_on <= t < off, where off is cs_rd_off for a read and cs_wr_off for a write. adv_n follows the same rule with adv_on, adv_rd_off and adv_wr_off.
- R5: During a read, oe_n is 0 for oe_on <= t < oe_off, and we_n stays 1. During a write, we_n is 0 for we_on <= t < we_off, and oe_n stays 1.
- R6: A strobe whose on tick is greater than or equal to its off tick never becomes active.
- R7: A strobe whose window reaches past tick L is released at the end of tick L. In the cycle after done, every strobe and mem_clk are inactive.
- R8: During a read, cap_stb is 1 in the tick equal to access_tick, provided that tick is no later than L. rd_q takes the value rd_data had during that tick, shows it from the next cycle, and holds it through later accesses until the next capture.
- R9: A start that arrives while an access is running, including one on tick L, is ignored. It neither restarts nor extends the access, and it launches no new access afterwards.
- R10: With sync_mode=1, mem_clk is 0 during tick t when floor(t/d) is even and 1 when it is odd, where d = clk_div + 1 (codes 0 to 3 give ratios 1 to 4). With sync_mode=0, mem_clk stays 0.
- R11: is_write, sync_mode and clk_div are taken only at launch. Changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, honoured only while idle |
| is_write | input | 1 | Direction of the access: 1 write, 0 read |
| sync_mode | input | 1 | 1 enables the memory clock output |
| clk_div | input | 2 | Memory clock divide ratio minus one |
| cs_on | input | 4 | Chip-select active tick |
| cs_rd_off | input | 5 | Chip-select release tick for reads |
| cs_wr_off | input | 5 | Chip-select release tick for writes |
| adv_on | input | 4 | Address-valid active tick |
| adv_rd_off | input | 5 | Address-valid release tick for reads |
| adv_wr_off | input | 5 | Address-valid release tick for writes |
| oe_on | input | 4 | Output-enable active tick |
| oe_off | input | 5 | Output-enable release tick |
| we_on | input | 4 | Write-enable active tick |
| we_off | input | 5 | Write-enable release tick |
| rd_cycle | input | 5 | Final tick of a read |
| wr_cycle | input | 5 | Final tick of a write |
| access_tick | input | 5 | Read data capture tick |
| rd_data | input | 16 | Read data bus from the memory |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| cap_stb | output | 1 | Marks the read capture tick |
| mem_clk | output | 1 | Memory clock in synchronous mode |
| done | output | 1 | One-cycle pulse on the final tick |
| rd_q | output | 16 | Captured read data |

## Verification
Asynchronous reads and writes with overlapping windows check that the direction picks the right release ticks and the right enable strobe. Synchronous accesses at all four divider codes check the phase of the memory clock against the tick count. Degenerate windows (on equal to off, on above off, off past the final tick), a zero-length access and a capture tick beyond the end check the edges of the window compare. Accesses that receive start pulses and flipped direction, mode and divider inputs while running, plus a start held on the final tick, separate a correct launch latch from one that samples live inputs or restarts.

// File: rtl/emt_pkg.sv
package emt_pkg;
  // default field widths shared by the sequencer and its bench
  localparam int EMT_ON_W   = 4;
  localparam int EMT_TICK_W = 5;
  localparam int EMT_DIV_W  = 2;

  // direction latched at launch
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } emt_dir_e;
endpackage

// File: rtl/emt_seq_ctrl.sv
module emt_seq_ctrl
  import emt_pkg::*;
#(
  parameter int TICK_W = EMT_TICK_W,
  parameter int DIV_W  = EMT_DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic              sync_mode,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [TICK_W-1:0] rd_cycle,
  input  logic [TICK_W-1:0] wr_cycle,
  output logic              launch,
  output logic              busy_nx,
  output logic [TICK_W-1:0] tick_nx,
  output logic              wr_nx,
  output logic              sync_nx,
  output logic [DIV_W-1:0]  div_nx,
  output logic              done
);
  logic              busy_q;
  logic [TICK_W-1:0] tick_q;
  emt_dir_e          dir_q, dir_nx;
  logic              sync_q;
  logic [DIV_W-1:0]  div_q;
  logic [TICK_W-1:0] last_q, last_nx;
  logic              done_nx;

  assign last_q = (dir_q == DIR_WR) ? wr_cycle : rd_cycle;

  // next-state: launch while idle, count while busy, stop after final tick
  always_comb begin
    busy_nx = busy_q;
    tick_nx = tick_q;
    dir_nx  = dir_q;
    sync_nx = sync_q;
    div_nx  = div_q;
    launch  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        launch  = 1'b1;
        busy_nx = 1'b1;
        tick_nx = '0;
        dir_nx  = is_write ? DIR_WR : DIR_RD;
        sync_nx = sync_mode;
        div_nx  = clk_div;
      end
    end else if (tick_q == last_q) begin
      busy_nx = 1'b0;
    end else begin
      tick_nx = tick_q + 1'b1;
    end
  end

  assign wr_nx   = (dir_nx == DIR_WR);
  assign last_nx = wr_nx ? wr_cycle : rd_cycle;
  assign done_nx = busy_nx && (tick_nx == last_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tick_q <= '0;
      dir_q  <= DIR_RD;
      sync_q <= 1'b0;
      div_q  <= '0;
      done   <= 1'b0;
    end else begin
      busy_q <= busy_nx;
      tick_q <= tick_nx;
      dir_q  <= dir_nx;
      sync_q <= sync_nx;
      div_q  <= div_nx;
      done   <= done_nx;
    end
  end
endmodule

// File: rtl/emt_strobe_win.sv
module emt_strobe_win #(
  parameter int ON_W    = 4,
  parameter int OFF_W   = 5,
  parameter int TICK_W  = 5,
  parameter bit ACT_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [TICK_W-1:0] tick,
  input  logic [ON_W-1:0]   on_tick,
  input  logic [OFF_W-1:0]  off_tick,
  output logic              strobe
);
  localparam int MW = (ON_W > OFF_W) ? ON_W : OFF_W;
  localparam int CW = ((MW > TICK_W) ? MW : TICK_W) + 1;

  logic [CW-1:0] t_x, on_x, off_x;
  logic          active_nx;
  logic          level_nx;

  assign t_x   = {{(CW-TICK_W){1'b0}}, tick};
  assign on_x  = {{(CW-ON_W){1'b0}}, on_tick};
  assign off_x = {{(CW-OFF_W){1'b0}}, off_tick};

  // half-open window [on, off): empty when on >= off
  assign active_nx = en && (t_x >= on_x) && (t_x < off_x);

  generate
    if (ACT_LOW) begin : g_low
      assign level_nx = ~active_nx;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe <= 1'b1;
        else        strobe <= level_nx;
      end
    end else begin : g_high
      assign level_nx = active_nx;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= level_nx;
      end
    end
  endgenerate
endmodule

// File: rtl/emt_clk_div.sv
module emt_clk_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             busy_nx,
  input  logic             sync_nx,
  input  logic [DIV_W-1:0] div_nx,
  output logic             mem_clk
);
  logic [DIV_W-1:0] cnt_q, cnt_nx;
  logic             clk_nx;

  // phase counter runs modulo (div+1); output toggles on each wrap
  always_comb begin
    cnt_nx = '0;
    clk_nx = 1'b0;
    if (launch) begin
      cnt_nx = '0;
      clk_nx = 1'b0;
    end else if (busy_nx) begin
      if (cnt_q == div_nx) begin
        cnt_nx = '0;
        clk_nx = sync_nx & ~mem_clk;
      end else begin
        cnt_nx = cnt_q + 1'b1;
        clk_nx = mem_clk;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mem_clk <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      mem_clk <= clk_nx;
    end
  end
endmodule

// File: rtl/emt_access_seq.sv
module emt_access_seq
  import emt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ON_W   = EMT_ON_W,
  parameter int TICK_W = EMT_TICK_W,
  parameter int DIV_W  = EMT_DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic              sync_mode,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [ON_W-1:0]   cs_on,
  input  logic [TICK_W-1:0] cs_rd_off,
  input  logic [TICK_W-1:0] cs_wr_off,
  input  logic [ON_W-1:0]   adv_on,
  input  logic [TICK_W-1:0] adv_rd_off,
  input  logic [TICK_W-1:0] adv_wr_off,
  input  logic [ON_W-1:0]   oe_on,
  input  logic [TICK_W-1:0] oe_off,
  input  logic [ON_W-1:0]   we_on,
  input  logic [TICK_W-1:0] we_off,
  input  logic [TICK_W-1:0] rd_cycle,
  input  logic [TICK_W-1:0] wr_cycle,
  input  logic [TICK_W-1:0] access_tick,
  input  logic [DATA_W-1:0] rd_data,
  output logic              cs_n,
  output logic              adv_n,
  output logic              oe_n,
  output logic              we_n,
  output logic              cap_stb,
  output logic              mem_clk,
  output logic              done,
  output logic [DATA_W-1:0] rd_q
);
  logic              launch;
  logic              busy_nx;
  logic [TICK_W-1:0] tick_nx;
  logic              wr_nx;
  logic              sync_nx;
  logic [DIV_W-1:0]  div_nx;
  logic [TICK_W-1:0] cs_off_sel, adv_off_sel;
  logic [TICK_W:0]   cap_off;
  logic [DATA_W-1:0] rd_nx;

  emt_seq_ctrl #(.TICK_W(TICK_W), .DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_write (is_write),
    .sync_mode(sync_mode),
    .clk_div  (clk_div),
    .rd_cycle (rd_cycle),
    .wr_cycle (wr_cycle),
    .launch   (launch),
    .busy_nx  (busy_nx),
    .tick_nx  (tick_nx),
    .wr_nx    (wr_nx),
    .sync_nx  (sync_nx),
    .div_nx   (div_nx),
    .done     (done)
  );

  // direction picks the release tick of the shared strobes
  assign cs_off_sel  = wr_nx ? cs_wr_off  : cs_rd_off;
  assign adv_off_sel = wr_nx ? adv_wr_off : adv_rd_off;
  // capture window is the single tick [access, access+1)
  assign cap_off     = {1'b0, access_tick} + {{TICK_W{1'b0}}, 1'b1};

  emt_strobe_win #(.ON_W(ON_W), .OFF_W(TICK_W), .TICK_W(TICK_W), .ACT_LOW(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_n), .en(busy_nx), .tick(tick_nx),
    .on_tick(cs_on), .off_tick(cs_off_sel), .strobe(cs_n)
  );

  emt_strobe_win #(.ON_W(ON_W), .OFF_W(TICK_W), .TICK_W(TICK_W), .ACT_LOW(1'b1)) u_adv (
    .clk(clk), .rst_n(rst_n), .en(busy_nx), .tick(tick_nx),
    .on_tick(adv_on), .off_tick(adv_off_sel), .strobe(adv_n)
  );

  emt_strobe_win #(.ON_W(ON_W), .OFF_W(TICK_W), .TICK_W(TICK_W), .ACT_LOW(1'b1)) u_oe (
    .clk(clk), .rst_n(rst_n), .en(busy_nx && !wr_nx), .tick(tick_nx),
    .on_tick(oe_on), .off_tick(oe_off), .strobe(oe_n)
  );

  emt_strobe_win #(.ON_W(ON_W), .OFF_W(TICK_W), .TICK_W(TICK_W), .ACT_LOW(1'b1)) u_we (
    .clk(clk), .rst_n(rst_n), .en(busy_nx && wr_nx), .tick(tick_nx),
    .on_tick(we_on), .off_tick(we_off), .strobe(we_n)
  );

  emt_strobe_win #(.ON_W(TICK_W), .OFF_W(TICK_W+1), .TICK_W(TICK_W), .ACT_LOW(1'b0)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(busy_nx && !wr_nx), .tick(tick_nx),
    .on_tick(access_tick), .off_tick(cap_off), .strobe(cap_stb)
  );

  emt_clk_div #(.DIV_W(DIV_W)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .busy_nx(busy_nx),
    .sync_nx(sync_nx),
    .div_nx (div_nx),
    .mem_clk(mem_clk)
  );

  // read data register, loaded at the end of the capture tick
  assign rd_nx = cap_stb ? rd_data : rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_nx;
  end
endmodule

// File: rtl/emt_access_seq_chk.sv
module emt_access_seq_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              cap_stb,
  input logic              mem_clk,
  input logic              done,
  input logic [DATA_W-1:0] rd_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cs_n && adv_n && oe_n && we_n && !mem_clk && !cap_stb)); // R7
  AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(!oe_n && !we_n)); // R5
  AST_CAPTURE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) cap_stb |-> we_n); // R8
  AST_RDQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cap_stb |=> $stable(rd_q)); // R8
endmodule

bind emt_access_seq emt_access_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n),
  .adv_n  (adv_n),
  .oe_n   (oe_n),
  .we_n   (we_n),
  .cap_stb(cap_stb),
  .mem_clk(mem_clk),
  .done   (done),
  .rd_q   (rd_q)
);

// File: tb/tb_emt_access_seq.sv
`timescale 1ns/1ps
module tb_emt_access_seq;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, is_write, sync_mode;
  logic [1:0] clk_div;
  logic [3:0] cs_on, adv_on, oe_on, we_on;
  logic [4:0] cs_rd_off, cs_wr_off, adv_rd_off, adv_wr_off, oe_off, we_off;
  logic [4:0] rd_cycle, wr_cycle, access_tick;
  logic [DW-1:0] rd_data;
  logic cs_n, adv_n, oe_n, we_n, cap_stb, mem_clk, done;
  logic [DW-1:0] rd_q;

  emt_access_seq #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .sync_mode(sync_mode), .clk_div(clk_div),
    .cs_on(cs_on), .cs_rd_off(cs_rd_off), .cs_wr_off(cs_wr_off),
    .adv_on(adv_on), .adv_rd_off(adv_rd_off), .adv_wr_off(adv_wr_off),
    .oe_on(oe_on), .oe_off(oe_off), .we_on(we_on), .we_off(we_off),
    .rd_cycle(rd_cycle), .wr_cycle(wr_cycle), .access_tick(access_tick),
    .rd_data(rd_data),
    .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
    .cap_stb(cap_stb), .mem_clk(mem_clk), .done(done), .rd_q(rd_q)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit compare_on = 1'b0;
  bit finished = 1'b0;
  int adv_seen, oe_seen, clk_seen;

  // reference model: expected bits {cs,adv,oe,we,cap,mclk,done}, active high
  logic [6:0] q[$];
  logic [6:0] cur;
  bit in_acc;
  logic [DW-1:0] exp_rd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = '0;
      in_acc = 1'b0;
      exp_rd = '0;
    end else begin
      if (cur[2]) exp_rd = rd_data;
      if (q.size() > 0) begin
        cur = q.pop_front();
      end else if (!in_acc && start) begin
        int len, d, cso, advo;
        len  = is_write ? int'(wr_cycle) : int'(rd_cycle);
        d    = int'(clk_div) + 1;
        cso  = is_write ? int'(cs_wr_off) : int'(cs_rd_off);
        advo = is_write ? int'(adv_wr_off) : int'(adv_rd_off);
        for (int t = 0; t <= len; t++) begin
          logic [6:0] e;
          e[6] = (t >= int'(cs_on)) && (t < cso);
          e[5] = (t >= int'(adv_on)) && (t < advo);
          e[4] = !is_write && (t >= int'(oe_on)) && (t < int'(oe_off));
          e[3] = is_write && (t >= int'(we_on)) && (t < int'(we_off));
          e[2] = !is_write && (t == int'(access_tick));
          e[1] = sync_mode && (((t / d) % 2) == 1);
          e[0] = (t == len);
          q.push_back(e);
        end
        cur = q.pop_front();
        in_acc = 1'b1;
      end else begin
        cur = '0;
        in_acc = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      chk(cs_n === ~cur[6], "R4 cs_n", cs_n, ~cur[6]);
      chk(adv_n === ~cur[5], "R4 adv_n", adv_n, ~cur[5]);
      chk(oe_n === ~cur[4], "R5 oe_n", oe_n, ~cur[4]);
      chk(we_n === ~cur[3], "R5 we_n", we_n, ~cur[3]);
      chk(cap_stb === cur[2], "R8 cap_stb", cap_stb, cur[2]);
      chk(mem_clk === cur[1], "R10 mem_clk", mem_clk, cur[1]);
      chk(done === cur[0], "R3 done", done, cur[0]);
      chk(rd_q === exp_rd, "R8 rd_q", rd_q, exp_rd);
      if (!adv_n) adv_seen++;
      if (!oe_n) oe_seen++;
      if (mem_clk) clk_seen++;
    end
  end

  always @(negedge clk) rd_data = rd_data + 16'h1357;

  // one access; disturb pulses start and flips launch inputs mid-access
  task automatic do_acc(input bit disturb, input bit start_at_done, input string tag);
    int n, len;
    logic sv_w, sv_s;
    logic [1:0] sv_d;
    len = is_write ? int'(wr_cycle) : int'(rd_cycle);
    sv_w = is_write; sv_s = sync_mode; sv_d = clk_div;
    adv_seen = 0; oe_seen = 0; clk_seen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 1;
    while (done !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
      if (disturb && n == 2) begin
        start = 1'b1; is_write = ~is_write; sync_mode = ~sync_mode; clk_div = ~clk_div;
      end
      if (disturb && n == 3) start = 1'b0;
    end
    is_write = sv_w; sync_mode = sv_s; clk_div = sv_d;
    chk(n == len + 1, {tag, " access length"}, n, len + 1);
    if (start_at_done) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(cs_n === 1'b1 && done === 1'b0, "R9 start on final tick", {cs_n, done}, 2'b10);
      repeat (3) @(negedge clk);
      chk(cs_n === 1'b1, "R9 no late launch", cs_n, 1);
    end else begin
      @(negedge clk);
      chk({cs_n, adv_n, oe_n, we_n, mem_clk} === 5'b11110, "R7 idle after done",
          {cs_n, adv_n, oe_n, we_n, mem_clk}, 5'b11110);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; is_write = 1'b0; sync_mode = 1'b0; clk_div = 2'd0;
    rd_data = 16'h00a5;
    cs_on = 4'd1; cs_rd_off = 5'd9; cs_wr_off = 5'd8;
    adv_on = 4'd0; adv_rd_off = 5'd3; adv_wr_off = 5'd2;
    oe_on = 4'd3; oe_off = 5'd9; we_on = 4'd2; we_off = 5'd7;
    rd_cycle = 5'd10; wr_cycle = 5'd9; access_tick = 5'd8;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk({cs_n, adv_n, oe_n, we_n, cap_stb, mem_clk, done} === 7'b1111000, "R1 strobes in reset",
        {cs_n, adv_n, oe_n, we_n, cap_stb, mem_clk, done}, 7'b1111000);
    chk(rd_q === '0, "R1 rd_q in reset", rd_q, 0);
    rst_n = 1'b1;
    compare_on = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n === 1'b1 && done === 1'b0, "R1 idle without start", {cs_n, done}, 2'b10);

    // R2 asynchronous read and write
    do_acc(1'b0, 1'b0, "R2 async read");
    chk(clk_seen == 0, "R10 async clock quiet", clk_seen, 0);
    is_write = 1'b1;
    do_acc(1'b0, 1'b0, "R2 async write");

    // R10 synchronous reads at every divider code
    is_write = 1'b0; sync_mode = 1'b1; rd_cycle = 5'd12; access_tick = 5'd7;
    for (int k = 0; k < 4; k++) begin
      clk_div = 2'(k);
      do_acc(1'b0, 1'b0, "R10 sync read");
    end
    is_write = 1'b1; clk_div = 2'd2;
    do_acc(1'b0, 1'b0, "R10 sync write");

    // R6 empty windows
    is_write = 1'b0; sync_mode = 1'b0;
    adv_on = 4'd5; adv_rd_off = 5'd5; oe_on = 4'd6; oe_off = 5'd4;
    do_acc(1'b0, 1'b0, "R6 empty windows");
    chk(adv_seen == 0, "R6 adv on==off", adv_seen, 0);
    chk(oe_seen == 0, "R6 oe on>off", oe_seen, 0);
    adv_on = 4'd0; adv_rd_off = 5'd3; oe_on = 4'd3; oe_off = 5'd9;

    // R7 windows past the final tick
    cs_rd_off = 5'd31; oe_off = 5'd31; rd_cycle = 5'd6; access_tick = 5'd2;
    do_acc(1'b0, 1'b0, "R7 long windows");

    // R8 zero-length access with capture on tick 0
    cs_on = 4'd0; cs_rd_off = 5'd1; rd_cycle = 5'd0; access_tick = 5'd0;
    do_acc(1'b0, 1'b0, "R8 single tick");

    // R8 capture tick beyond the end: rd_q holds
    cs_on = 4'd1; cs_rd_off = 5'd9; rd_cycle = 5'd10; access_tick = 5'd20; oe_off = 5'd9;
    do_acc(1'b0, 1'b0, "R8 no capture");

    // R11 and R9: inputs flipped and start pulsed mid-access
    is_write = 1'b1; sync_mode = 1'b1; clk_div = 2'd1;
    do_acc(1'b1, 1'b0, "R11 launch latch");
    is_write = 1'b0; sync_mode = 1'b0; access_tick = 5'd4;
    do_acc(1'b1, 1'b0, "R11 read latch");

    // R9 start held on the final tick
    cs_on = 4'd0;
    do_acc(1'b0, 1'b1, "R9 final tick start");

    // R8 back to back: write leaves captured data untouched
    is_write = 1'b1;
    do_acc(1'b0, 1'b0, "R8 write keeps rd_q");
    is_write = 1'b0; access_tick = 5'd5;
    do_acc(1'b0, 1'b0, "R8 new capture");

    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      report();
    end
  end
endmodule